// File: doc/BRIEF.md
# Compare-Match Interval Timer

This block is an 8-bit programmable interval timer with a register port. A free-running prescaler divides the system clock and produces single-cycle count pulses at one of four selectable rates. Each pulse advances an up-counter. On a pulse where the counter already equals the reference register, three things happen together: the counter returns to zero, an interrupt request flag is raised, and an output latch driving a pin is inverted. Counting then carries on without any action from software.

Software sets up the prescaler code, the reference value and the interrupt enable. It then writes the start bit, which clears the counter, the request flag, the output latch and the prescaler in one step. Counting can be paused at any time without losing the count, and the held count stays readable. Software clears the request flag by writing 0 to it.

Top module: `cmp_timer`

## Requirements
- R1: After reset, every register reads 0, and `irq` and `tout` are 0.
- R2: Register map, selected by `addr`: 0 is the mode register, 1 the reference, 2 the counter, 3 the flags (bit 0 interrupt enable, bit 1 request flag). Mode bits 7:4 and 2 are stored and read back as written. Mode bits 3, 1 and 0 always read 0.
- R3: The prescaler code in mode bits 5:4 selects one count pulse every 2^10, 2^6, 2^4 or 2^1 clock cycles for codes 00, 01, 10 and 11. The first pulse comes 2^n cycles after the start edge.
- R4: On a pulse where the counter differs from the reference, the counter goes up by one. On a pulse where it equals the reference, the counter loads 0, the request flag is set and `tout` inverts. A match therefore occurs every (reference + 1) pulses, and a reference of 0 matches on every pulse.
- R5: A write to the mode register with bit 3 set clears the counter, the request flag, `tout` and the prescaler. This clear wins over a match on the same edge.
- R6: Counting happens only while mode bit 2 = 1, bit 6 = 1 and bit 7 = 0. In any other state the counter holds its value and stays readable.
- R7: `irq` is 1 exactly when the request flag and the interrupt enable are both 1.
- R8: Writing flags bit 1 = 0 clears the request flag, and writing 1 leaves it unchanged. A match on the same edge as a clearing write leaves the flag set.
- R9: Writes to the counter address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Interrupt request (flag and enable) |
| tout | output | 1 | Toggle output latch |

## Verification
Two pairs of events can land on the same clock edge: a compare match together with a start write, and a compare match together with a software write that clears the request flag. The bench finds the exact edge of a known match, which is a whole number of prescaled pulses after the start, and times the colliding write so that it takes effect on that edge. A start must leave the counter, the flag and `tout` at zero. A flag clear must lose, leaving the flag and `irq` at 1 and `tout` inverted.

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int W     = 8,
  parameter int PRE_W = 10,
  parameter int SH0   = 10,
  parameter int SH1   = 6,
  parameter int SH2   = 4,
  parameter int SH3   = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         irq,
  output logic         tout
);
  localparam logic [PRE_W-1:0] ONES = {PRE_W{1'b1}};
  localparam logic [PRE_W-1:0] M0 = ONES >> (PRE_W - SH0);
  localparam logic [PRE_W-1:0] M1 = ONES >> (PRE_W - SH1);
  localparam logic [PRE_W-1:0] M2 = ONES >> (PRE_W - SH2);
  localparam logic [PRE_W-1:0] M3 = ONES >> (PRE_W - SH3);

  logic [7:0]       mode_q;
  logic [W-1:0]     ref_q, cnt_q;
  logic [PRE_W-1:0] pre_q, sel_mask;
  logic             flag_q, ie_q, tol_q;

  always_comb begin
    case (mode_q[5:4])
      2'd0:    sel_mask = M0;
      2'd1:    sel_mask = M1;
      2'd2:    sel_mask = M2;
      default: sel_mask = M3;
    endcase
  end

  wire run     = mode_q[2] & mode_q[6] & ~mode_q[7];
  wire tick    = run && ((pre_q & sel_mask) == sel_mask);
  wire wr_mode = wr_en && addr == 2'd0;
  wire start   = wr_mode && wdata[3];
  wire hit     = tick && cnt_q == ref_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ref_q  <= '0;
      cnt_q  <= '0;
      pre_q  <= '0;
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
      tol_q  <= 1'b0;
    end else begin
      pre_q <= start ? '0 : pre_q + 1'b1;
      if (wr_mode) mode_q <= {wdata[7:4], 1'b0, wdata[2], 2'b00};
      if (wr_en && addr == 2'd1) ref_q <= wdata;
      if (wr_en && addr == 2'd3) begin
        ie_q <= wdata[0];
        if (!wdata[1]) flag_q <= 1'b0;
      end
      if (start) begin
        cnt_q  <= '0;
        flag_q <= 1'b0;
        tol_q  <= 1'b0;
      end else if (hit) begin
        cnt_q  <= '0;
        flag_q <= 1'b1;
        tol_q  <= ~tol_q;
      end else if (tick) begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = W'(mode_q);
      2'd1:    rdata = ref_q;
      2'd2:    rdata = cnt_q;
      default: rdata = W'({flag_q, ie_q});
    endcase
  end

  assign irq  = flag_q & ie_q;
  assign tout = tol_q;
endmodule

module cmp_timer_chk #(parameter int W = 8) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [1:0]   addr,
  input logic [W-1:0] wdata,
  input logic [7:0]   mode,
  input logic [W-1:0] cnt,
  input logic [W-1:0] refv,
  input logic         tick,
  input logic         flag,
  input logic         ie,
  input logic         irq,
  input logic         tout
);
  wire st = wr_en && addr == 2'd0 && wdata[3];

  // R5
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st |=> (cnt == '0 && !flag && !tout));

  // R4
  match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == refv && !st) |=> (cnt == '0 && flag && tout != $past(tout)));

  // R4
  incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt != refv && !st) |=> cnt == W'($past(cnt) + 1'b1));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(mode[2] && mode[6] && !mode[7]) && !st) |=> $stable(cnt));

  // R3
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag && ie));
endmodule

bind cmp_timer cmp_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .mode(mode_q), .cnt(cnt_q), .refv(ref_q), .tick(tick), .flag(flag_q),
  .ie(ie_q), .irq(irq), .tout(tout)
);

// File: tb/cmp_timer_tb.sv
module cmp_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq, tout;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  cmp_timer u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .tout(tout));

  // {code, ref, edges after start, exp count, exp tout, exp flag}
  localparam logic [35:0] VEC [7] = '{
    {2'd3, 8'd5,   16'd10,   8'd5,  1'b0, 1'b0},
    {2'd3, 8'd5,   16'd12,   8'd0,  1'b1, 1'b1},
    {2'd3, 8'd0,   16'd7,    8'd0,  1'b1, 1'b1},
    {2'd2, 8'd3,   16'd100,  8'd2,  1'b1, 1'b1},
    {2'd1, 8'd1,   16'd260,  8'd0,  1'b0, 1'b1},
    {2'd0, 8'd2,   16'd3100, 8'd0,  1'b1, 1'b1},
    {2'd3, 8'd255, 16'd600,  8'd44, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d, held;
    #23 rst_n = 1'b1;
    @(negedge clk);
    // R1
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1 register reset", d, 0);
    end
    chk("R1 irq reset", irq, 0);
    chk("R1 tout reset", tout, 0);

    // R2 stored bits and zero-read bits
    wr(2'd0, 8'h7F);
    rd(2'd0, d);
    chk("R2 mode readback", d, 8'h74);

    // R3 R4 vector walk
    for (int i = 0; i < 7; i++) begin
      logic [1:0]  code;
      logic [7:0]  rv, ec;
      logic [15:0] k;
      logic        et, ef;
      {code, rv, k, ec, et, ef} = VEC[i];
      wr(2'd1, rv);
      wr(2'd3, 8'h01);
      wr(2'd0, {2'b01, code, 4'b1100});
      repeat (k) @(posedge clk);
      @(negedge clk);
      rd(2'd2, d);
      chk($sformatf("R3 R4 count vec%0d", i), d, ec);
      chk($sformatf("R4 tout vec%0d", i), tout, et);
      rd(2'd3, d);
      chk($sformatf("R4 flag vec%0d", i), d[1], ef);
      chk($sformatf("R7 irq vec%0d", i), irq, ef);
    end

    // R6 hold on run bit, clock enable and cascade bit; R9 counter write ignored
    wr(2'd1, 8'd200);
    wr(2'd0, 8'h7C);
    repeat (20) @(posedge clk);
    wr(2'd0, 8'h70);
    rd(2'd2, held);
    chk("R6 count at stop", held, 10);
    repeat (30) @(posedge clk);
    @(negedge clk);
    rd(2'd2, d);
    chk("R6 held with run bit 0", d, 10);
    wr(2'd2, 8'h55);
    rd(2'd2, d);
    chk("R9 counter write ignored", d, 10);
    wr(2'd0, 8'h34);
    repeat (30) @(posedge clk);
    @(negedge clk);
    rd(2'd2, d);
    chk("R6 held with clock enable 0", d, 10);
    wr(2'd0, 8'hF4);
    repeat (30) @(posedge clk);
    @(negedge clk);
    rd(2'd2, d);
    chk("R6 held with cascade bit 1", d, 10);
    wr(2'd0, 8'h74);
    repeat (20) @(posedge clk);
    @(negedge clk);
    rd(2'd2, d);
    chk("R6 resumes from held count", int'(d > 8'd10), 1);

    // R5 start on the same edge as a match
    wr(2'd1, 8'd2);
    wr(2'd3, 8'h01);
    wr(2'd0, 8'h7C);
    repeat (5) @(posedge clk);
    wr(2'd0, 8'h7C);
    rd(2'd2, d);
    chk("R5 start beats match count", d, 0);
    rd(2'd3, d);
    chk("R5 start beats match flag", d[1], 0);
    chk("R5 start beats match tout", tout, 0);

    // R8 flag clear on the same edge as a match
    repeat (5) @(posedge clk);
    wr(2'd3, 8'h01);
    rd(2'd3, d);
    chk("R8 match beats clear flag", d[1], 1);
    chk("R8 match beats clear irq", irq, 1);
    chk("R4 collision tout", tout, 1);

    // R7 R8 masking and clearing
    wr(2'd0, 8'h70);
    wr(2'd3, 8'h02);
    rd(2'd3, d);
    chk("R7 flag kept when masked", d[1], 1);
    chk("R7 irq masked", irq, 0);
    wr(2'd3, 8'h01);
    rd(2'd3, d);
    chk("R8 write 0 clears flag", d[1], 0);
    chk("R7 irq low after clear", irq, 0);
    wr(2'd3, 8'h03);
    rd(2'd3, d);
    chk("R8 write 1 does not set flag", d[1], 0);

    finish_run();
  end
endmodule